// File: doc/BRIEF.md
# Mode Unlock Sequence Detector

This block sits beside a small register file and decides whether the module may leave its default (standard) register layout for the extended (enhanced) one. It watches every bus access: the read and write strobes, the register address, the written byte and the current interrupt-enable state. The switch happens only when a fixed four-byte key is written to the mask register at address 7. The key must be the very first activity after a reset, must arrive with no other access between its bytes, and must be written while interrupts are disabled.

Any departure from that rule locks the detector in standard mode until the next hardware or software reset. Once enhanced mode is reached, the flag stays set until a reset. The key writes are ordinary writes to address 7, so the mask register elsewhere in the module still takes them. Accesses are single-cycle strobes with zero wait states. There is no valid/ready handshake and no back-pressure, because every access completes in the cycle its strobe is high. Idle cycles, with no strobe high, are not accesses and do not disturb the sequence.

Top module: `mode_unlock`

## Requirements
- R1: After hardware reset (`rst_n` low), `enh_mode` reads 0.
- R2: The four writes 07h, 0Dh, 06h, 12h, in that order to address 7 and with `irq_en` low, raise `enh_mode` one clock after the strobe of the fourth write.
- R3: A key write made while `irq_en` is high locks the detector, so the sequence cannot complete before the next reset.
- R4: A read of any address at any point before unlock locks the detector.
- R5: A write to any address other than 7 before unlock locks the detector.
- R6: A write to address 7 whose byte is not the key byte due at that position locks the detector. This includes restarting the key from 07h part way through. A full correct key written afterwards leaves `enh_mode` at 0.
- R7: Clock cycles with neither strobe high do not advance, reset or lock the sequence.
- R8: Once `enh_mode` is 1, it stays 1 under any later access until a reset.
- R9: A one-cycle `soft_rst` clears the flag, the progress and the lockout, after which a correct key unlocks again.
- R10: A cycle with both `rd_stb` and `wr_stb` high counts as a non-key access and locks the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| rd_stb | input | 1 | Read access strobe, one cycle per access |
| wr_stb | input | 1 | Write access strobe, one cycle per access |
| addr | input | ADDR_W (3) | Register address of the access |
| wdata | input | 8 | Write data byte |
| irq_en | input | 1 | Interrupt enable state, high means enabled |
| enh_mode | output | 1 | Sticky enhanced-mode flag |

## Verification
The bench sweeps every byte value and every address into each of the four key positions. A decoder that compared the wrong position, or that ignored the address, would then unlock on a foreign byte or a foreign address, or would fail on the true key.

Other cases are aimed at designs that skip the lockout. A wrong byte or a restarted key followed by the correct key must stay locked, which catches a design that rewinds its counter instead of locking. A read, a write with interrupts enabled, or a double strobe at each position catches a design that screens only write data. Idle gaps between key bytes catch a design that counts cycles instead of accesses. Accesses after unlock and a software reset catch a flag that is not sticky or that cannot be cleared.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int KEY_LEN  = 4;
  localparam int DATA_W   = 8;
  localparam int STEP_W   = 3;

  function automatic logic [DATA_W-1:0] key_byte(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    key_byte = 8'h07;
      3'd1:    key_byte = 8'h0D;
      3'd2:    key_byte = 8'h06;
      3'd3:    key_byte = 8'h12;
      default: key_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/unlock_access_decode.sv
module unlock_access_decode
  import unlock_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int KEY_PORT = 7
) (
  input  logic                  rd_stb,
  input  logic                  wr_stb,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  irq_en,
  input  logic [STEP_W-1:0]     step,
  output logic                  access,
  output logic                  key_hit
);
  localparam logic [ADDR_W-1:0] PORT_SEL = ADDR_W'(KEY_PORT);

  logic port_write;

  always_comb begin
    access     = rd_stb | wr_stb;
    port_write = wr_stb & ~rd_stb & (addr == PORT_SEL);
    key_hit    = port_write & ~irq_en & (wdata == key_byte(step));
  end
endmodule

// File: rtl/unlock_seq_tracker.sv
module unlock_seq_tracker
  import unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              access,
  input  logic              key_hit,
  output logic [STEP_W-1:0] step,
  output logic              enh
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_LEN - 1);

  logic locked;
  logic armed;

  assign armed = ~enh & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= '0;
      locked <= 1'b0;
      enh    <= 1'b0;
    end else if (soft_rst) begin
      step   <= '0;
      locked <= 1'b0;
      enh    <= 1'b0;
    end else if (access && armed) begin
      if (!key_hit) begin
        locked <= 1'b1;
      end else if (step == LAST) begin
        enh <= 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mode_unlock.sv
module mode_unlock
  import unlock_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int KEY_PORT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              irq_en,
  output logic              enh_mode
);
  logic [STEP_W-1:0] step;
  logic              access;
  logic              key_hit;

  unlock_access_decode #(.ADDR_W(ADDR_W), .KEY_PORT(KEY_PORT)) u_dec (
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .addr   (addr),
    .wdata  (wdata),
    .irq_en (irq_en),
    .step   (step),
    .access (access),
    .key_hit(key_hit)
  );

  unlock_seq_tracker u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .access  (access),
    .key_hit (key_hit),
    .step    (step),
    .enh     (enh_mode)
  );
endmodule

// File: rtl/mode_unlock_chk.sv
module mode_unlock_chk #(
  parameter int ADDR_W   = 3,
  parameter int KEY_PORT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              irq_en,
  input logic              enh_mode
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !enh_mode);

  // R2
  a_r2_rise_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(wr_stb && !rd_stb && !irq_en && !soft_rst &&
                              addr == ADDR_W'(KEY_PORT) && wdata == 8'h12));

  // R3
  a_r3_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && irq_en && !enh_mode) |=> !enh_mode);

  // R4
  a_r4_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !enh_mode) |=> !enh_mode);

  // R5
  a_r5_other_port_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr != ADDR_W'(KEY_PORT) && !enh_mode) |=> !enh_mode);

  // R7
  a_r7_idle_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb && !enh_mode) |=> !enh_mode);

  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    enh_mode |=> enh_mode);

  // R9
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !enh_mode);
endmodule

bind mode_unlock mode_unlock_chk #(.ADDR_W(ADDR_W), .KEY_PORT(KEY_PORT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .soft_rst(soft_rst),
  .rd_stb  (rd_stb),
  .wr_stb  (wr_stb),
  .addr    (addr),
  .wdata   (wdata),
  .irq_en  (irq_en),
  .enh_mode(enh_mode)
);

// File: tb/sim_mode_unlock.sv
module sim_mode_unlock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       irq_en = 1'b0;
  logic       enh_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mode_unlock u0 (.*);

  function automatic logic [7:0] kb(input int i);
    logic [7:0] k [4];
    k = '{8'h07, 8'h0D, 8'h06, 8'h12};
    return k[i];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: enh_mode=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acc(input logic r, input logic w, input logic [2:0] a,
                     input logic [7:0] d, input logic ie);
    @(negedge clk);
    rd_stb = r; wr_stb = w; addr = a; wdata = d; irq_en = ie;
    @(negedge clk);
    rd_stb = 0; wr_stb = 0; irq_en = 0;
  endtask

  task automatic key_from(input int first);
    for (int i = first; i < 4; i++) acc(0, 1, 3'd7, kb(i), 0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run hung, enh_mode=%0b expected completion", enh_mode);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    hw_reset();
    check("R1", enh_mode, 1'b0);

    // R2: plain key; flag low before the last write, high after it
    key_from(0);
    check("R2", enh_mode, 1'b1);
    hw_reset();
    check("R1", enh_mode, 1'b0);
    for (int i = 0; i < 3; i++) acc(0, 1, 3'd7, kb(i), 0);
    check("R2", enh_mode, 1'b0);
    acc(0, 1, 3'd7, kb(3), 0);
    check("R2", enh_mode, 1'b1);

    // R6 / R2: every byte in every position, then finish with the true key
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        hw_reset();
        for (int i = 0; i < p; i++) acc(0, 1, 3'd7, kb(i), 0);
        acc(0, 1, 3'd7, 8'(v), 0);
        key_from(p + 1);
        check((v == int'(kb(p))) ? "R2" : "R6", enh_mode, v == int'(kb(p)));
        if (v != int'(kb(p))) begin
          key_from(0);
          check("R6", enh_mode, 1'b0);
        end
      end
    end

    // R5 / R4 / R3 / R10 at every position and address
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 8; a++) begin
        hw_reset();
        for (int i = 0; i < p; i++) acc(0, 1, 3'd7, kb(i), 0);
        acc(0, 1, 3'(a), kb(p), 0);
        key_from(p + 1);
        check((a == 7) ? "R2" : "R5", enh_mode, a == 7);
        hw_reset();
        for (int i = 0; i < p; i++) acc(0, 1, 3'd7, kb(i), 0);
        acc(1, 0, 3'(a), 8'h00, 0);
        key_from(p);
        check("R4", enh_mode, 1'b0);
      end
      hw_reset();
      for (int i = 0; i < p; i++) acc(0, 1, 3'd7, kb(i), 0);
      acc(0, 1, 3'd7, kb(p), 1);
      key_from(p + 1);
      check("R3", enh_mode, 1'b0);
      hw_reset();
      for (int i = 0; i < p; i++) acc(0, 1, 3'd7, kb(i), 0);
      acc(1, 1, 3'd7, kb(p), 0);
      key_from(p + 1);
      check("R10", enh_mode, 1'b0);
    end

    // R6: restarting the key part way
    hw_reset();
    acc(0, 1, 3'd7, kb(0), 0);
    key_from(0);
    check("R6", enh_mode, 1'b0);

    // R7: idle gaps, with irq_en toggling while idle
    hw_reset();
    for (int i = 0; i < 4; i++) begin
      acc(0, 1, 3'd7, kb(i), 0);
      @(negedge clk); irq_en = 1;
      repeat (i + 2) @(negedge clk);
      irq_en = 0;
    end
    @(negedge clk);
    check("R7", enh_mode, 1'b1);

    // R8: any access after unlock
    for (int a = 0; a < 8; a++) begin
      acc(1, 0, 3'(a), 8'h00, 1);
      acc(0, 1, 3'(a), 8'hA5, 1);
      acc(1, 1, 3'(a), 8'h07, 0);
      check("R8", enh_mode, 1'b1);
    end

    // R9: soft reset clears flag, then lockout
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    check("R9", enh_mode, 1'b0);
    key_from(0);
    check("R9", enh_mode, 1'b1);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    acc(1, 0, 3'd0, 8'h00, 0);
    key_from(0);
    check("R9", enh_mode, 1'b0);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    key_from(0);
    check("R9", enh_mode, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule